// File: doc/BRIEF.md
# Card Session Time-Out Counter

This block measures time-outs during a smart-card session in units of elementary time units (ETUs). It holds three 8-bit counters. In the split mode, counter 1 is an 8-bit counter that reloads itself after each expiry. Counters 3 and 2 are joined into one 16-bit count that fires once and then halts. The host sets the three reload bytes and a mode byte through a small write port.

Counting is not started by the mode write. Writing the split mode only arms the block. Both counts are loaded and begin decrementing on the first start bit that the UART reports after that write. The start bit may come from reception or from transmission.

Each time a counter reaches zero it raises a sticky flag and a one-cycle interrupt pulse. The host re-arms the block, or halts it, by writing the mode byte again.

Top module: `card_timeout`

## Requirements
- R1: After reset, all three reload bytes are zero, all flags and interrupt pulses are low, and no counter is running. A zero reload byte for counter 1 means a period of 256 ticks.
- R2: When `wr_en` is high, `wr_sel` chooses the target of `wr_data`: 0 is the counter 1 reload, 1 is the counter 2 reload, 2 is the counter 3 reload and 3 is the mode byte. In the chained count, counter 3 supplies the upper byte and counter 2 the lower byte.
- R3: Writing mode 0x75 arms the block, and ticks have no effect until a start bit arrives. A start bit in the same cycle as the mode write does not start counting.
- R4: Once started, counter 1 fires every N ticks, where N is its reload value. At each expiry `tmo_irq[0]` is high for the one cycle after the tick, and the counter reloads.
- R5: The chained counter fires once, after {reload3, reload2} ticks (zero means 65536). At that expiry `tmo_irq[2]` pulses and the chain stops.
- R6: A start bit that arrives while counting is already under way has no effect on either count.
- R7: Writing mode 0x00 halts both counters and clears all flags. The reload bytes keep their values for the next session.
- R8: Any mode value other than 0x75 behaves as 0x00.
- R9: Rewriting 0x75 while counting discards the running counts, clears the flags and re-arms the block for a new start bit.
- R10: Flags are sticky until the next mode write. `tmo_flag[0]` is set by counter 1 and `tmo_flag[2]` by the chain. `tmo_flag[1]` and `tmo_irq[1]` stay 0 in every mode.
- R11: A tick in the same cycle as the starting start bit is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target select (see R2) |
| wr_data | input | 8 | Write data |
| start_bit | input | 1 | Start bit detected on the card I/O line (one-cycle pulse) |
| etu_tick | input | 1 | One pulse per ETU |
| tmo_flag | output | 3 | Sticky expiry flags: [2] chain, [1] counter 2, [0] counter 1 |
| tmo_irq | output | 3 | One-cycle expiry pulses, same bit order as the flags |

## Verification
The hardest states to reach are the ones where events coincide with the arming or starting of the block. These include a start bit arriving on the same cycle as the mode write, a tick on the same cycle as the starting start bit, and a re-arm partway through a count. The stimulus forces each of these on purpose, then applies a further run of ticks so that any miscount shows up as a shifted interrupt. The 256-tick period for a zero reload, and the placement of the upper byte in the chain, are both covered by a long run with reloads of 0 and {1, 5}.

// File: rtl/tocnt_pkg.sv
// Shared constants for the card time-out counter.
// Assumes an 8-bit host data path and a fixed set of three counters.
package tocnt_pkg;
    localparam int NCNT = 3;

    // Write targets (R2)
    localparam logic [1:0] SEL_RLD1 = 2'd0;
    localparam logic [1:0] SEL_RLD2 = 2'd1;
    localparam logic [1:0] SEL_RLD3 = 2'd2;
    localparam logic [1:0] SEL_MODE = 2'd3;

    // The only defined running mode; all other values halt the block
    localparam logic [7:0] MODE_SPLIT = 8'h75;
endpackage

// File: rtl/tocnt_regs.sv
// Host-writable reload bytes and mode-write decode.
// Assumes one write per cycle. Reload bytes are write-only and are cleared by reset.
module tocnt_regs
    import tocnt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [CW-1:0]        wr_data,
    output logic [NCNT*CW-1:0]   rld_o,
    output logic                 cfg_wr_o,
    output logic                 split_o
);
    for (genvar i = 0; i < NCNT; i++) begin : g_rld
        logic [CW-1:0] q;
        // Capture the reload byte addressed by this index
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_sel == 2'(i))
                q <= wr_data;
        end
        assign rld_o[i*CW +: CW] = q;
    end

    // Mode write strobe and decode of the running mode
    assign cfg_wr_o = wr_en && (wr_sel == SEL_MODE);
    assign split_o  = (wr_data == CW'(MODE_SPLIT));
endmodule

// File: rtl/tocnt_arm.sv
// Start trigger: armed by a split-mode write, fired by the first later start bit.
// Assumes start_bit is a one-cycle pulse. A mode write always wins over a coincident start bit.
module tocnt_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr_i,
    input  logic split_i,
    input  logic start_bit_i,
    output logic go_o
);
    logic arm_q;

    assign go_o = arm_q && start_bit_i && !cfg_wr_i;

    // Arm on a split-mode write; disarm on any other mode write or on the trigger
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm_q <= 1'b0;
        else if (cfg_wr_i)
            arm_q <= split_i;
        else if (go_o)
            arm_q <= 1'b0;
    end

    // R6: the trigger fires only once per arming
    a_r6_single_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q && start_bit_i && !cfg_wr_i |=> !arm_q);
    // R8: a non-split mode write leaves the block unarmed
    a_r8_other_mode_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_i && !split_i |=> !arm_q);
endmodule

// File: rtl/tocnt_down.sv
// Down counter clocked by ETU ticks. A load value of zero gives a full 2**W period.
// AUTO picks the behaviour at expiry: reload and keep running, or halt.
// Priority: stop, then load, then tick. The expiry pulse is registered.
module tocnt_down #(
    parameter int W    = 8,
    parameter bit AUTO = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop_i,
    input  logic         load_i,
    input  logic         tick_i,
    input  logic [W-1:0] val_i,
    output logic         exp_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic         run_q;
    logic         exp_q;
    logic [W-1:0] nxt_cnt;
    logic         nxt_run;

    if (AUTO) begin : g_auto
        assign nxt_cnt = val_i;
        assign nxt_run = 1'b1;
        // R4: an auto-reload counter is still running after it fires
        a_r4_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
            exp_q |-> run_q);
    end else begin : g_once
        assign nxt_cnt = '0;
        assign nxt_run = 1'b0;
        // R5: a one-shot counter halts when it fires
        a_r5_chain_halts: assert property (@(posedge clk) disable iff (!rst_n)
            exp_q |-> !run_q);
    end

    // Count, load, halt and fire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (stop_i) begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end else if (load_i) begin
                cnt_q <= val_i;
                run_q <= 1'b1;
            end else if (run_q && tick_i) begin
                if (cnt_q == ONE) begin
                    exp_q <= 1'b1;
                    cnt_q <= nxt_cnt;
                    run_q <= nxt_run;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end

    assign exp_o = exp_q;

    // R7: a mode write silences the counter on the next cycle
    a_r7_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !exp_q && !run_q);
    // R3: no expiry comes from an idle counter
    a_r3_idle_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> !exp_q);
endmodule

// File: rtl/card_timeout.sv
// Card session time-out engine. Counter 1 auto-reloads. Counters 3 and 2
// are chained into a one-shot 16-bit count. Both start on the first start
// bit after the split mode is written.
// Assumes etu_tick and start_bit are one-cycle pulses in the clk domain.
module card_timeout
    import tocnt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic          start_bit,
    input  logic          etu_tick,
    output logic [2:0]    tmo_flag,
    output logic [2:0]    tmo_irq
);
    localparam int CHW = 2 * CW;

    logic [NCNT*CW-1:0] rld;
    logic               cfg_wr;
    logic               split;
    logic               go;
    logic               exp_c1;
    logic               exp_ch;
    logic [2:0]         flag_q;

    tocnt_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rld_o(rld), .cfg_wr_o(cfg_wr), .split_o(split)
    );

    tocnt_arm u_arm (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .split_i(split),
        .start_bit_i(start_bit), .go_o(go)
    );

    tocnt_down #(.W(CW), .AUTO(1'b1)) u_c1 (
        .clk(clk), .rst_n(rst_n), .stop_i(cfg_wr), .load_i(go),
        .tick_i(etu_tick), .val_i(rld[0 +: CW]), .exp_o(exp_c1)
    );

    tocnt_down #(.W(CHW), .AUTO(1'b0)) u_chain (
        .clk(clk), .rst_n(rst_n), .stop_i(cfg_wr), .load_i(go),
        .tick_i(etu_tick), .val_i(rld[CW +: CHW]), .exp_o(exp_ch)
    );

    assign tmo_irq = {exp_ch, 1'b0, exp_c1};

    // Sticky flags, cleared by any mode write
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else if (cfg_wr)
            flag_q <= '0;
        else
            flag_q <= flag_q | tmo_irq;
    end

    assign tmo_flag = flag_q;

    // R10: a set chain flag persists until a mode write
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[2] && !cfg_wr |=> flag_q[2]);
    // R7: a mode write clears every flag
    a_r7_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> tmo_flag == 3'b000);
    // R4: a counter 1 pulse is followed by its flag
    a_r4_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
        exp_c1 && !cfg_wr |=> tmo_flag[0]);
endmodule

// File: tb/card_timeout_tb.sv
module card_timeout_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       start_bit = 1'b0;
    logic       etu_tick = 1'b0;
    logic [2:0] tmo_flag;
    logic [2:0] tmo_irq;

    always #5 clk = ~clk;

    card_timeout u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .start_bit(start_bit), .etu_tick(etu_tick),
        .tmo_flag(tmo_flag), .tmo_irq(tmo_irq)
    );

    typedef struct {
        int         cyc;
        logic [2:0] m;
        string      tag;
    } ev_t;

    ev_t   evq[$];
    int    vectors = 0;
    int    miscompares = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference state, derived from the requirements
    bit         b_armed = 0;
    bit         b_act = 0;
    bit         b_chain = 0;
    int         b_k = 0;
    int         r_c1 = 0;
    int         r_c2 = 0;
    int         r_c3 = 0;
    logic [2:0] e_flag = 3'b000;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop the expected pulse for this cycle and compare
    always @(negedge clk) begin
        logic [2:0] e;
        string      t;
        if (rst_n && !done) begin
            e = 3'b000;
            t = cur_req;
            if (evq.size() > 0 && evq[0].cyc == cyc) begin
                e = evq[0].m;
                t = evq[0].tag;
                void'(evq.pop_front());
            end
            vectors++;
            if (tmo_irq !== e) begin
                miscompares++;
                $display("FAIL %s irq actual=%b expected=%b at cycle %0d", t, tmo_irq, e, cyc);
            end
        end
    end

    function automatic void activate();
        b_armed = 0;
        b_act   = 1;
        b_chain = 1;
        b_k     = 0;
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [7:0] d, input bit with_start = 0);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = d;
        start_bit = with_start;
        case (sel)
            2'd0: r_c1 = d;
            2'd1: r_c2 = d;
            2'd2: r_c3 = d;
            default: begin
                b_armed = (d == 8'h75);
                b_act   = 0;
                b_chain = 0;
                e_flag  = 3'b000;
            end
        endcase
        @(negedge clk);
        wr_en = 1'b0;
        start_bit = 1'b0;
    endtask

    task automatic start_pulse();
        @(negedge clk);
        start_bit = 1'b1;
        if (b_armed) activate();
        @(negedge clk);
        start_bit = 1'b0;
    endtask

    // Driver: one tick, optionally with a start bit; push the expected pulse
    task automatic tick_once(input bit with_start = 0);
        logic [2:0] m;
        int per;
        int len;
        @(negedge clk);
        etu_tick  = 1'b1;
        start_bit = with_start;
        m = 3'b000;
        if (with_start && b_armed) begin
            activate();
        end else if (b_act) begin
            b_k++;
            per = (r_c1 == 0) ? 256 : r_c1;
            len = (r_c3 * 256 + r_c2 == 0) ? 65536 : r_c3 * 256 + r_c2;
            if (b_k % per == 0) m[0] = 1'b1;
            if (b_chain && b_k == len) begin
                m[2] = 1'b1;
                b_chain = 0;
            end
        end
        if (m != 3'b000) begin
            evq.push_back('{cyc + 1, m, cur_req});
            e_flag |= m;
        end
        @(negedge clk);
        etu_tick  = 1'b0;
        start_bit = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_once(0);
    endtask

    task automatic chk_flags(input string tag);
        @(negedge clk);
        @(negedge clk);
        vectors++;
        if (tmo_flag !== e_flag) begin
            miscompares++;
            $display("FAIL %s flags actual=%b expected=%b", tag, tmo_flag, e_flag);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state; zero reload for counter 1 gives 256 ticks
        cur_req = "R1";
        chk_flags("R1");
        wr(2'd3, 8'h75);
        start_pulse();
        ticks(260);
        chk_flags("R1");

        // R2/R4/R5/R3: reloads 3 and {0,0x10}; ticks before start are ignored
        cur_req = "R3";
        wr(2'd0, 8'd3);
        wr(2'd1, 8'h10);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h75);
        chk_flags("R9");
        ticks(4);
        start_pulse();
        cur_req = "R4";
        ticks(18);
        // R6: a start bit during counting changes nothing
        cur_req = "R6";
        start_pulse();
        ticks(20);
        chk_flags("R10");

        // R7: halt mode clears flags, ignores ticks, keeps reloads
        cur_req = "R7";
        wr(2'd3, 8'h00);
        chk_flags("R7");
        ticks(5);
        start_pulse();
        ticks(3);
        wr(2'd3, 8'h75);
        start_pulse();
        ticks(7);

        // R8: an undefined mode value behaves as halt
        cur_req = "R8";
        wr(2'd3, 8'h12);
        chk_flags("R8");
        start_pulse();
        ticks(6);

        // R9: rewriting the split mode mid-count restarts from the next start bit
        cur_req = "R9";
        wr(2'd3, 8'h75);
        start_pulse();
        ticks(2);
        wr(2'd3, 8'h75);
        ticks(3);
        start_pulse();
        ticks(4);

        // R3: a start bit coinciding with the mode write is not a trigger
        cur_req = "R3";
        wr(2'd3, 8'h75, 1);
        ticks(4);
        start_pulse();
        ticks(4);

        // R11: a tick in the starting cycle is not counted
        cur_req = "R11";
        wr(2'd3, 8'h75);
        tick_once(1);
        ticks(4);

        // R2/R5: chain upper byte from counter 3; counter 1 reload of zero
        cur_req = "R2";
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd5);
        wr(2'd2, 8'd1);
        wr(2'd3, 8'h75);
        start_pulse();
        cur_req = "R5";
        ticks(264);
        chk_flags("R5");

        repeat (4) @(negedge clk);
        if (evq.size() != 0) begin
            miscompares++;
            $display("FAIL R4 pending expected pulses actual=%0d expected=0", evq.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule